// File: doc/BRIEF.md
# Multi-View Video Memory Address Translator

This block sits between a host bus and a linear, byte-addressed video memory. It maps one host window onto that memory in several ways at once. The two top address bits choose the view. The linear view passes 32-bit words and single bytes straight through. The 16-bit interleaved view and the 32-bit plane view rearrange the address so that one byte lane of every pixel sits at consecutive host addresses. In the plane view, for example, all red bytes form one contiguous run and all green bytes form another.

For each host strobe the block produces, one clock later, a byte offset into video memory, a read or write pulse, byte enables, and write data placed in memory byte order. It also pulses a dirty flag when a linear write lands inside the visible frame (four bytes per pixel). Read data comes back combinationally from the memory, gated by the registered state of the pending read. The reserved colour-reorder view returns zero on reads. Writes through any non-linear view are rejected and signalled with a one-cycle error pulse. Video memory size is a power-of-two parameter of at most 16 MiB.

Top module: `vvx_xlate`

## Requirements
- R1: Host address bits 25:24 select the view: 00 linear, 01 colour-reorder (reserved), 10 interleaved 16-bit, 11 plane.
- R2: In the linear view the memory offset is the host address masked to the memory size (VRAM_BYTES−1).
- R3: In the interleaved 16-bit view the offset is ((address×2) masked to the memory size) plus address bit 23.
- R4: In the plane view the offset is ((address×4) masked to the memory size) plus address bits 23:22.
- R5: Size code 10 is a 32-bit word that must be 4-byte aligned. It is big-endian: the byte at the lowest offset occupies data bits 31:24. A word write drives byte enables 1111 and the host data unchanged. A word read returns the memory word unchanged.
- R6: Size code 00 is a byte. Lane k = offset[1:0] occupies bits 31−8k down to 24−8k and uses byte enable bit 3−k. A byte write replicates the byte into all four lanes. A byte read returns the lane zero-extended.
- R7: mem_re, mem_we, err, dirty and host_rvalid are one-cycle pulses that appear in the clock cycle after the strobe. They are all low when no strobe is applied.
- R8: A linear write pulses dirty only if its offset is below 4 × fb_width × fb_height.
- R9: A byte or aligned-word read in the colour-reorder view returns zero with host_rvalid, no memory read and no error.
- R10: A write in any view other than linear produces no mem_we and one err pulse.
- R11: A half-word (01) or reserved (11) size, a misaligned word, or a non-byte read in the 16-bit or plane view is rejected. No memory access takes place, err pulses, and a read returns zero with host_rvalid.
- R12: After reset all pulse outputs are low.
- R13: Read and write strobes together are rejected: err pulses and there is no memory access and no host_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 26 | Host byte address; bits 25:24 pick the view |
| host_rd | input | 1 | Read strobe |
| host_wr | input | 1 | Write strobe |
| host_size | input | 2 | 00 byte, 01 half, 10 word, 11 reserved |
| host_wdata | input | 32 | Write data (byte in bits 7:0) |
| fb_width | input | 12 | Visible width in pixels |
| fb_height | input | 12 | Visible height in lines |
| mem_rdata | input | 32 | Memory word at mem_off (combinational) |
| mem_off | output | 23 | Video memory byte offset |
| mem_re | output | 1 | Memory read pulse |
| mem_we | output | 1 | Memory write pulse |
| mem_be | output | 4 | Byte enables, bit 3 = lowest byte |
| mem_wdata | output | 32 | Lane-placed write data |
| host_rdata | output | 32 | Read data to host |
| host_rvalid | output | 1 | Read data valid pulse |
| dirty | output | 1 | Visible-frame write pulse |
| err | output | 1 | Rejected access pulse |

## Verification
Two functions can land in the same cycle. One is the dirty decision for a linear write; the other is the rejection logic, which fires when a read strobe arrives together with that write. The bench raises both strobes at once, in directed cases and in about one random cycle in eight. It then expects err alone, with no mem_we, no dirty and no host_rvalid. Separately, linear writes are placed just below and exactly at the 4 × width × height limit to judge where dirty stops.

// File: rtl/vvx_pkg.sv
package vvx_pkg;
  typedef enum logic [1:0] {
    VIEW_LIN = 2'b00,
    VIEW_BGR = 2'b01,
    VIEW_I16 = 2'b10,
    VIEW_PLN = 2'b11
  } view_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSV  = 2'b11
  } size_e;

  typedef struct packed {
    logic rd_go;
    logic wr_go;
    logic rzero;
    logic rvalid;
    logic err;
    logic word;
  } acc_s;
endpackage

// File: rtl/vvx_view_decode.sv
module vvx_view_decode
  import vvx_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int OFF_W  = 23
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              rd,
  input  logic              wr,
  output logic [OFF_W-1:0]  off,
  output acc_s              acc
);
  localparam int SEL_MSB = ADDR_W - 3;

  view_e view;
  logic  is_byte, is_word;
  logic [OFF_W-1:0] off_lin, off_i16, off_pln;

  assign view    = view_e'(addr[ADDR_W-1 -: 2]);
  assign is_byte = (size_e'(size) == SZ_BYTE);
  assign is_word = (size_e'(size) == SZ_WORD) && (addr[1:0] == 2'b00);

  assign off_lin = addr[OFF_W-1:0];
  assign off_i16 = {addr[OFF_W-2:0], 1'b0} + OFF_W'(addr[SEL_MSB]);
  assign off_pln = {addr[OFF_W-3:0], 2'b00} + OFF_W'(addr[SEL_MSB -: 2]);

  always_comb begin
    unique case (view)
      VIEW_I16: off = off_i16;
      VIEW_PLN: off = off_pln;
      default:  off = off_lin;
    endcase
  end

  always_comb begin
    acc      = '0;
    acc.word = is_word;
    if (rd && wr) begin
      acc.err = 1'b1;
    end else if (wr) begin
      if (view == VIEW_LIN && (is_byte || is_word)) acc.wr_go = 1'b1;
      else                                          acc.err   = 1'b1;
    end else if (rd) begin
      acc.rvalid = 1'b1;
      unique case (view)
        VIEW_LIN: begin
          if (is_byte || is_word) acc.rd_go = 1'b1;
          else begin acc.err = 1'b1; acc.rzero = 1'b1; end
        end
        VIEW_BGR: begin
          acc.rzero = 1'b1;
          acc.err   = !(is_byte || is_word);
        end
        default: begin
          if (is_byte) acc.rd_go = 1'b1;
          else begin acc.err = 1'b1; acc.rzero = 1'b1; end
        end
      endcase
    end
  end

  always_comb begin
    if (rd && wr) assert (!acc.rd_go && !acc.wr_go); // R13
  end
endmodule

// File: rtl/vvx_lane_pack.sv
module vvx_lane_pack #(
  parameter int DATA_W = 32,
  localparam int NLANE = DATA_W / 8,
  localparam int LW    = $clog2(NLANE)
) (
  input  logic [LW-1:0]     wr_lane,
  input  logic              wr_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [NLANE-1:0]  be,
  output logic [DATA_W-1:0] wdata_mem,
  input  logic [LW-1:0]     rd_lane,
  input  logic              rd_word,
  input  logic              rd_zero,
  input  logic [DATA_W-1:0] rdata_mem,
  output logic [DATA_W-1:0] rdata_host
);
  logic [7:0] lane_b [NLANE];
  logic [7:0] rbyte;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign be[NLANE-1-g] = wr_word || (wr_lane == LW'(g));
    assign wdata_mem[DATA_W-1-8*g -: 8] = wr_word ? wdata[DATA_W-1-8*g -: 8]
                                                  : wdata[7:0];
    assign lane_b[g] = rdata_mem[DATA_W-1-8*g -: 8];
  end

  assign rbyte = lane_b[rd_lane];

  always_comb begin
    if (rd_zero)      rdata_host = '0;
    else if (rd_word) rdata_host = rdata_mem;
    else              rdata_host = {{(DATA_W-8){1'b0}}, rbyte};
  end
endmodule

// File: rtl/vvx_dirty_cmp.sv
module vvx_dirty_cmp #(
  parameter int OFF_W = 23,
  parameter int DIM_W = 12,
  localparam int LIM_W = 2 * DIM_W + 2
) (
  input  logic [OFF_W-1:0] off,
  input  logic [DIM_W-1:0] fb_w,
  input  logic [DIM_W-1:0] fb_h,
  output logic             hit
);
  logic [2*DIM_W-1:0] area;
  logic [LIM_W-1:0]   limit;

  assign area  = fb_w * fb_h;
  assign limit = {area, 2'b00};
  assign hit   = LIM_W'(off) < limit;
endmodule

// File: rtl/vvx_xlate.sv
module vvx_xlate
  import vvx_pkg::*;
#(
  parameter int VRAM_BYTES = 8 * 1024 * 1024,
  parameter int DIM_W      = 12,
  localparam int ADDR_W    = 26,
  localparam int DATA_W    = 32,
  localparam int NLANE     = DATA_W / 8,
  localparam int LW        = $clog2(NLANE),
  localparam int OFF_W     = $clog2(VRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [1:0]        host_size,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DIM_W-1:0]  fb_width,
  input  logic [DIM_W-1:0]  fb_height,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OFF_W-1:0]  mem_off,
  output logic              mem_re,
  output logic              mem_we,
  output logic [NLANE-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              dirty,
  output logic              err
);
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [OFF_W-1:0]  off_d;
  acc_s              acc_d;
  logic              hit_d;
  logic [NLANE-1:0]  be_d;
  logic [DATA_W-1:0] wdat_d;
  logic              load_en;

  logic              word_q, zero_q;

  vvx_view_decode #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_dec (
    .addr (host_addr), .size (host_size), .rd (host_rd), .wr (host_wr),
    .off  (off_d),     .acc  (acc_d)
  );

  vvx_dirty_cmp #(.OFF_W(OFF_W), .DIM_W(DIM_W)) u_dirty (
    .off (off_d), .fb_w (fb_width), .fb_h (fb_height), .hit (hit_d)
  );

  vvx_lane_pack #(.DATA_W(DATA_W)) u_pack (
    .wr_lane    (off_d[LW-1:0]), .wr_word (acc_d.word), .wdata (host_wdata),
    .be         (be_d),          .wdata_mem (wdat_d),
    .rd_lane    (mem_off[LW-1:0]), .rd_word (word_q), .rd_zero (zero_q),
    .rdata_mem  (mem_rdata),     .rdata_host (host_rdata)
  );

  // next-state for the pulse outputs
  logic re_d, we_d, rv_d, err_d, dirty_d;
  always_comb begin
    load_en = host_rd || host_wr;
    re_d    = acc_d.rd_go;
    we_d    = acc_d.wr_go;
    rv_d    = acc_d.rvalid;
    err_d   = acc_d.err;
    dirty_d = acc_d.wr_go && hit_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mem_re      <= 1'b0;
      mem_we      <= 1'b0;
      host_rvalid <= 1'b0;
      err         <= 1'b0;
      dirty       <= 1'b0;
    end else begin
      mem_re      <= re_d;
      mem_we      <= we_d;
      host_rvalid <= rv_d;
      err         <= err_d;
      dirty       <= dirty_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mem_off   <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      word_q    <= 1'b0;
      zero_q    <= 1'b0;
    end else if (load_en) begin
      mem_off   <= off_d;
      mem_be    <= be_d;
      mem_wdata <= wdat_d;
      word_q    <= acc_d.word;
      zero_q    <= acc_d.rzero;
    end
  end

  AST_DIRTY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_q_n)
    dirty |-> mem_we); // R8
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_q_n)
    err |-> (!mem_we && !mem_re)); // R10
  AST_NO_RD_AND_WR: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(mem_re && mem_we)); // R13
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we |-> ($countones(mem_be) == 1 || mem_be == '1)); // R6
  AST_LIN_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_q_n)
    mem_we |-> (mem_off == $past(host_addr[OFF_W-1:0]))); // R2
  AST_READ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_q_n)
    host_rvalid |-> $past(host_rd)); // R7
endmodule

// File: tb/sim_vvx_xlate.sv
`timescale 1ns/1ps
module sim_vvx_xlate;
  localparam int VRAM = 8 * 1024 * 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic [11:0] fb_width = 12'd64, fb_height = 12'd64;
  logic [31:0] mem_rdata;
  logic [22:0] mem_off;
  logic        mem_re, mem_we, host_rvalid, dirty, err;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, host_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] pat(input logic [22:0] off);
    logic [31:0] w;
    w = 32'(off >> 2);
    return (w * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  assign mem_rdata = pat(mem_off);

  vvx_xlate u0 (
    .clk (clk), .rst_n (rst_n), .host_addr (host_addr), .host_rd (host_rd),
    .host_wr (host_wr), .host_size (host_size), .host_wdata (host_wdata),
    .fb_width (fb_width), .fb_height (fb_height), .mem_rdata (mem_rdata),
    .mem_off (mem_off), .mem_re (mem_re), .mem_we (mem_we), .mem_be (mem_be),
    .mem_wdata (mem_wdata), .host_rdata (host_rdata),
    .host_rvalid (host_rvalid), .dirty (dirty), .err (err)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected offset per view (R1..R4)
  function automatic logic [22:0] e_off(input logic [25:0] a);
    longint la = longint'(a);
    case (a[25:24])
      2'b10:   return 23'(((la * 2) % VRAM) + a[23]);
      2'b11:   return 23'(((la * 4) % VRAM) + a[23:22]);
      default: return 23'(la % VRAM);
    endcase
  endfunction

  task automatic access(input string tag, input bit rd, input bit wr,
                        input logic [1:0] sz, input logic [25:0] a,
                        input logic [31:0] wd);
    bit ok_byte, ok_word, x_re, x_we, x_err, x_rv, x_zero, x_dirty;
    logic [22:0] o;
    logic [31:0] x_rd, x_wd;
    logic [3:0]  x_be;
    longint lim;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_size = sz; host_addr = a; host_wdata = wd;
    ok_byte = (sz == 2'b00);
    ok_word = (sz == 2'b10) && (a[1:0] == 2'b00);
    o = e_off(a);
    x_re = 0; x_we = 0; x_err = 0; x_rv = 0; x_zero = 0;
    if (rd && wr) x_err = 1;                                     // R13
    else if (wr) begin
      if (a[25:24] == 2'b00 && (ok_byte || ok_word)) x_we = 1;
      else x_err = 1;                                            // R10, R11
    end else if (rd) begin
      x_rv = 1;
      if (a[25:24] == 2'b01) begin x_zero = 1; x_err = !(ok_byte || ok_word); end // R9
      else if (ok_byte || (ok_word && a[25:24] == 2'b00)) x_re = 1;
      else begin x_zero = 1; x_err = 1; end                      // R11
    end
    lim = 4 * longint'(fb_width) * longint'(fb_height);
    x_dirty = x_we && (longint'(o) < lim);                       // R8
    x_be = ok_word ? 4'hF : (4'b1000 >> o[1:0]);                 // R5, R6
    x_wd = ok_word ? wd : {4{wd[7:0]}};
    if (x_zero) x_rd = 32'h0;
    else if (ok_word) x_rd = pat(o);
    else x_rd = 32'(pat(o) >> (8 * (3 - o[1:0]))) & 32'hFF;
    @(posedge clk); #1;
    chk(tag, "mem_re", 32'(mem_re), 32'(x_re));
    chk(tag, "mem_we", 32'(mem_we), 32'(x_we));
    chk(tag, "err", 32'(err), 32'(x_err));
    chk(tag, "rvalid", 32'(host_rvalid), 32'(x_rv));
    chk(tag, "dirty", 32'(dirty), 32'(x_dirty));
    if (x_we || x_re) chk(tag, "mem_off", 32'(mem_off), 32'(o));
    if (x_we) begin
      chk(tag, "mem_be", 32'(mem_be), 32'(x_be));
      chk(tag, "mem_wdata", mem_wdata, x_wd);
    end
    if (x_rv) chk(tag, "host_rdata", host_rdata, x_rd);
  endtask

  task automatic idle_check(input string tag);
    @(negedge clk);
    host_rd = 0; host_wr = 0;
    @(posedge clk); #1;
    chk(tag, "idle pulses", {27'b0, mem_re, mem_we, err, host_rvalid, dirty}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #1;
    chk("R12", "reset pulses", {27'b0, mem_re, mem_we, err, host_rvalid, dirty}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R12", "post-release pulses", {27'b0, mem_re, mem_we, err, host_rvalid, dirty}, 32'h0);

    // directed corner cases
    access("R6_byte_write", 0, 1, 2'b00, 26'h000_0005, 32'h0000_00A5);
    chk("R6", "lane1 be", 32'(mem_be), 32'h4);
    access("R8_below", 0, 1, 2'b10, 26'h000_3FFC, 32'h1122_3344);
    chk("R8", "dirty last word", 32'(dirty), 32'h1);
    access("R8_at_limit", 0, 1, 2'b00, 26'h000_4000, 32'h0000_0077);
    chk("R8", "dirty at limit", 32'(dirty), 32'h0);
    access("R2_wrap", 0, 1, 2'b10, 26'h090_0004, 32'hDEAD_BEEF);
    chk("R2", "masked off", 32'(mem_off), 32'h0010_0004);
    access("R5_word_read", 1, 0, 2'b10, 26'h000_0008, 32'h0);
    access("R3_i16", 1, 0, 2'b00, 26'h280_0003, 32'h0);
    chk("R3", "odd subwindow off", 32'(mem_off), 32'h7);
    access("R4_plane", 1, 0, 2'b00, 26'h3C0_0005, 32'h0);
    chk("R4", "R-plane off", 32'(mem_off), 32'h17);
    access("R1_views", 1, 0, 2'b00, 26'h300_0001, 32'h0);
    access("R9_bgr", 1, 0, 2'b00, 26'h100_0010, 32'h0);
    chk("R9", "bgr zero", host_rdata, 32'h0);
    access("R10_plane_wr", 0, 1, 2'b00, 26'h3C0_0000, 32'h55);
    access("R10_i16_wr", 0, 1, 2'b10, 26'h200_0000, 32'h55);
    access("R11_half", 1, 0, 2'b01, 26'h000_0010, 32'h0);
    access("R11_misalign", 0, 1, 2'b10, 26'h000_0012, 32'h0);
    access("R11_plane_word", 1, 0, 2'b10, 26'h300_0000, 32'h0);
    access("R13_both", 1, 1, 2'b00, 26'h000_0004, 32'h9);
    idle_check("R7");

    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [25:0] a;
      logic [1:0]  sz;
      int          k;
      if (i % 50 == 0) begin
        @(negedge clk);
        fb_width  = 12'(1 + $urandom % 64);
        fb_height = 12'(1 + $urandom % 64);
      end
      a = 26'($urandom);
      if ($urandom % 2 == 0) a[23:0] = a[23:0] & 24'h00_7FFF;
      sz = 2'($urandom);
      if ($urandom % 2 == 0) a[1:0] = 2'b00;
      k = $urandom % 8;
      if (k < 4)      access("R1_rand_rd", 1, 0, sz, a, 32'($urandom));
      else if (k < 7) access("R8_rand_wr", 0, 1, sz, a, 32'($urandom));
      else            access("R13_rand_both", 1, 1, sz, a, 32'($urandom));
      if (i % 37 == 0) idle_check("R7");
    end

    idle_check("R7");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule